// File: doc/BRIEF.md
# Reaction Game Round Controller

This block runs the rounds of a single-player reaction game. It rests in an idle state until a start request arrives. It then waits for the current four-beat group to finish, and after that opens a round. During a round the player must press the button pattern that matches an externally supplied target before a fixed number of beat ticks has passed. A press is confirmed only if the window is still open when the controller checks it. Each confirmed press adds one point to the score, requests a fresh target and starts a new window. A wrong press, or a window that runs out, ends the game. The score is then cleared and the controller goes back to idle.

Beat and group ticks come from an external tempo source. Targets come from an external generator, which the controller prompts through a one-cycle request. The button bus is asynchronous to the clock. The controller synchronises it and reacts only to rising edges, so a held button counts once.

Top module: `reaction_round_ctrl`

## Requirements
- R1: After reset, `enable`, `gameActive` and `nextTarget` are low and `score` is 0.
- R2: A one-cycle `startIn` pulse in idle raises `enable` one clock later. `gameActive` stays low until a `groupTick` pulse is taken, and goes high one clock after that pulse.
- R3: A `startIn` pulse while a round is open has no effect: `gameActive` stays high and `score` is unchanged.
- R4: In a round with no press, three beat ticks leave the round open. After the fourth beat tick has been counted, the round still shows as open for one more clock, and on the next clock `enable` and `gameActive` fall.
- R5: A press whose synchronised button bus differs from `target` (buttons nonzero) drops `enable` three clocks after the bus changes. The score reads 0 one clock after that.
- R6: A press whose synchronised bus equals `target` makes `nextTarget` high for exactly one clock, three clocks after the bus changes. `score` rises by one a clock later and the round remains open with a fresh window.
- R7: A matching press is detected in the same clock in which the window expires. No point is awarded and the game ends: `score` keeps its old value on the clock where `enable` falls.
- R8: Only rising edges of the button bus are compared. Holding a matching pattern scores once, and a pattern pressed and held before the round opens causes neither a hit nor a miss.
- R9: `score` is `SCORE_W` bits (8 by default) and saturates at its maximum value (255) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Request to begin a game |
| beatTick | input | 1 | One-cycle pulse per beat |
| groupTick | input | 1 | One-cycle pulse at the end of each four-beat group |
| buttons | input | BTN_W (3) | Raw player button bus, asynchronous |
| target | input | BTN_W (3) | Pattern the player must press |
| enable | output | 1 | High whenever a game is in progress |
| nextTarget | output | 1 | One-cycle request for a new target |
| score | output | SCORE_W (8) | Points in the current game |
| gameActive | output | 1 | High while a response window is open |

## Verification
A change on the button bus reaches the comparator after two synchroniser stages. The state register moves on the third clock. So a miss drops `enable` three clocks after the change, `nextTarget` shows on that same third clock, and the new score appears on the fourth. Control inputs such as `startIn` and `groupTick` take effect one clock after the pulse. A counted fourth beat closes the round one clock later. The bench drives every input just after a rising edge and samples exactly that many edges later, one time unit past the edge. In the R7 corner, the fourth beat is placed so that it is counted on the same edge that captures the hit.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GROUP   = 2'd1,
    ST_RESULT  = 2'd2,
    ST_CONFIRM = 2'd3
  } roundState_e;

  typedef struct packed {
    logic timerClr;
    logic timerRun;
    logic cmpEn;
    logic scoreClr;
    logic scoreInc;
  } ctrlStrobes_t;

endpackage

// File: rtl/rr_datapath.sv
module rr_datapath
  import rr_pkg::*;
#(
  parameter int BTN_W       = 3,
  parameter int SCORE_W     = 8,
  parameter int TIMER_W     = 3,
  parameter int ROUND_BEATS = 4,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strobes,
  input  logic               beatTick,
  input  logic [BTN_W-1:0]   buttons,
  input  logic [BTN_W-1:0]   target,
  output logic               hit,
  output logic               miss,
  output logic               timeOver,
  output logic [SCORE_W-1:0] score
);

  localparam logic [TIMER_W-1:0] BEAT_LIMIT = TIMER_W'(ROUND_BEATS);
  localparam logic [SCORE_W-1:0] SCORE_MAX  = {SCORE_W{1'b1}};

  logic [BTN_W-1:0] syncQ [SYNC_DEPTH];
  logic [BTN_W-1:0] btnPrev;
  logic [BTN_W-1:0] btnNow;
  logic             pressEvt;
  logic [TIMER_W-1:0] beatCnt;

  // synchroniser chain for the asynchronous button bus
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_DEPTH; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          syncQ[gi] <= '0;
        end else if (gi == 0) begin
          syncQ[gi] <= buttons;
        end else begin
          syncQ[gi] <= syncQ[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  assign btnNow = syncQ[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) btnPrev <= '0;
    else        btnPrev <= btnNow;
  end

  assign pressEvt = |(btnNow & ~btnPrev);
  assign hit      = strobes.cmpEn && pressEvt && (btnNow == target);
  assign miss     = strobes.cmpEn && pressEvt && (btnNow != target);

  // round window timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beatCnt <= '0;
    end else if (strobes.timerClr) begin
      beatCnt <= '0;
    end else if (strobes.timerRun && beatTick && !timeOver) begin
      beatCnt <= beatCnt + TIMER_W'(1);
    end
  end

  assign timeOver = (beatCnt >= BEAT_LIMIT);

  // score register, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      score <= '0;
    end else if (strobes.scoreClr) begin
      score <= '0;
    end else if (strobes.scoreInc && score != SCORE_MAX) begin
      score <= score + SCORE_W'(1);
    end
  end

endmodule

// File: rtl/rr_control.sv
module rr_control
  import rr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startIn,
  input  logic         groupTick,
  input  logic         hit,
  input  logic         miss,
  input  logic         timeOver,
  output ctrlStrobes_t strobes,
  output logic         enable,
  output logic         nextTarget,
  output logic         gameActive
);

  roundState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:    if (startIn) stateD = ST_GROUP;
      ST_GROUP:   if (groupTick) stateD = ST_RESULT;
      ST_RESULT: begin
        if (miss)          stateD = ST_IDLE;
        else if (hit)      stateD = ST_CONFIRM;
        else if (timeOver) stateD = ST_IDLE;
      end
      ST_CONFIRM: stateD = timeOver ? ST_IDLE : ST_RESULT;
      default:    stateD = ST_IDLE;
    endcase
  end

  logic confirmOk;
  assign confirmOk = (stateQ == ST_CONFIRM) && !timeOver;

  always_comb begin
    strobes.timerClr = (stateQ == ST_IDLE) || (stateQ == ST_GROUP) || confirmOk;
    strobes.timerRun = (stateQ == ST_RESULT) || (stateQ == ST_CONFIRM);
    strobes.cmpEn    = (stateQ == ST_RESULT);
    strobes.scoreClr = (stateQ == ST_IDLE);
    strobes.scoreInc = confirmOk;
  end

  assign enable     = (stateQ != ST_IDLE);
  assign gameActive = (stateQ == ST_RESULT) || (stateQ == ST_CONFIRM);
  assign nextTarget = confirmOk;

endmodule

// File: rtl/reaction_round_ctrl.sv
module reaction_round_ctrl
  import rr_pkg::*;
#(
  parameter int BTN_W       = 3,
  parameter int SCORE_W     = 8,
  parameter int TIMER_W     = 3,
  parameter int ROUND_BEATS = 4,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startIn,
  input  logic               beatTick,
  input  logic               groupTick,
  input  logic [BTN_W-1:0]   buttons,
  input  logic [BTN_W-1:0]   target,
  output logic               enable,
  output logic               nextTarget,
  output logic [SCORE_W-1:0] score,
  output logic               gameActive
);

  ctrlStrobes_t strobes;
  logic hit, miss, timeOver;

  rr_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startIn    (startIn),
    .groupTick  (groupTick),
    .hit        (hit),
    .miss       (miss),
    .timeOver   (timeOver),
    .strobes    (strobes),
    .enable     (enable),
    .nextTarget (nextTarget),
    .gameActive (gameActive)
  );

  rr_datapath #(
    .BTN_W       (BTN_W),
    .SCORE_W     (SCORE_W),
    .TIMER_W     (TIMER_W),
    .ROUND_BEATS (ROUND_BEATS),
    .SYNC_DEPTH  (SYNC_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .beatTick (beatTick),
    .buttons  (buttons),
    .target   (target),
    .hit      (hit),
    .miss     (miss),
    .timeOver (timeOver),
    .score    (score)
  );

endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
  parameter int SCORE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               nextTarget,
  input logic [SCORE_W-1:0] score,
  input logic               gameActive
);

  localparam logic [SCORE_W-1:0] SMAX = {SCORE_W{1'b1}};

  AST_IDLE_CLEARS_SCORE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> score == '0); // R5

  AST_SCORE_ONLY_ON_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !nextTarget) |=> score == $past(score)); // R6

  AST_NEXT_TARGET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    nextTarget |=> !nextTarget); // R6

  AST_NEXT_TARGET_IN_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    nextTarget |-> gameActive); // R6

  AST_ROUND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    gameActive |-> enable); // R2

  AST_SCORE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && score == SMAX) |=> score == SMAX); // R9

endmodule

bind reaction_round_ctrl rr_checker #(.SCORE_W(SCORE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .nextTarget (nextTarget),
  .score      (score),
  .gameActive (gameActive)
);

// File: tb/tb_reaction_round_ctrl.sv
`timescale 1ns/1ps
module tb_reaction_round_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startIn = 1'b0;
  logic       beatTick = 1'b0;
  logic       groupTick = 1'b0;
  logic [2:0] buttons = '0;
  logic [2:0] target = 3'd5;
  logic       enable, nextTarget, gameActive;
  logic [7:0] score;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  reaction_round_ctrl dut (
    .clk(clk), .rst_n(rst_n), .startIn(startIn), .beatTick(beatTick),
    .groupTick(groupTick), .buttons(buttons), .target(target),
    .enable(enable), .nextTarget(nextTarget), .score(score),
    .gameActive(gameActive)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // start a game and open the first round
  task automatic openRound();
    startIn = 1'b1; step(1); startIn = 1'b0;
    groupTick = 1'b1; step(1); groupTick = 1'b0;
  endtask

  task automatic beat();
    beatTick = 1'b1; step(1); beatTick = 1'b0; step(1);
  endtask

  task automatic release_btn();
    buttons = '0; step(3);
  endtask

  task automatic t_reset();
    check("R1 enable", enable, 0);
    check("R1 gameActive", gameActive, 0);
    check("R1 nextTarget", nextTarget, 0);
    check("R1 score", score, 0);
  endtask

  task automatic t_start();
    startIn = 1'b1; step(1); startIn = 1'b0;
    check("R2 enable after start", enable, 1);
    check("R2 gameActive before group", gameActive, 0);
    step(3);
    check("R2 still waiting for group", gameActive, 0);
    groupTick = 1'b1; step(1); groupTick = 1'b0;
    check("R2 round open", gameActive, 1);
  endtask

  task automatic t_hit();
    buttons = target; step(3);
    check("R6 nextTarget pulse", nextTarget, 1);
    step(1);
    check("R6 nextTarget one cycle", nextTarget, 0);
    check("R6 score incremented", score, 1);
    check("R6 round stays open", gameActive, 1);
    release_btn();
  endtask

  task automatic t_start_ignored();
    startIn = 1'b1; step(1); startIn = 1'b0; step(2);
    check("R3 round still open", gameActive, 1);
    check("R3 score unchanged", score, 1);
  endtask

  task automatic t_miss();
    buttons = 3'd2; step(2);
    check("R5 enable before miss lands", enable, 1);
    step(1);
    check("R5 enable dropped", enable, 0);
    step(1);
    check("R5 score cleared", score, 0);
    release_btn();
  endtask

  task automatic t_timeout();
    openRound();
    beat(); beat(); beat();
    check("R4 open after three beats", gameActive, 1);
    beatTick = 1'b1; step(1); beatTick = 1'b0;
    check("R4 open on expiry clock", enable, 1);
    step(1);
    check("R4 enable low after timeout", enable, 0);
    check("R4 gameActive low after timeout", gameActive, 0);
  endtask

  task automatic t_late_hit();
    openRound();
    buttons = target; step(4); release_btn();
    check("R7 setup score", score, 1);
    beat(); beat(); beat();
    buttons = target; step(2);
    beatTick = 1'b1; step(1); beatTick = 1'b0;
    step(1);
    check("R7 game ended", enable, 0);
    check("R7 no point awarded", score, 1);
    release_btn();
  endtask

  task automatic t_held();
    startIn = 1'b1; step(1); startIn = 1'b0;
    buttons = 3'd3; step(4);
    groupTick = 1'b1; step(1); groupTick = 1'b0; step(4);
    check("R8 early held press ignored", gameActive, 1);
    release_btn();
    buttons = target; step(12);
    check("R8 held press scores once", score, 1);
    check("R8 still open while held", gameActive, 1);
    release_btn();
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 255; k++) begin
      buttons = target; step(4); buttons = '0; step(3);
    end
    check("R9 reached max", score, 255);
    buttons = target; step(4); buttons = '0; step(3);
    check("R9 saturated", score, 255);
    check("R9 round still open", gameActive, 1);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_start();
    t_hit();
    t_start_ignored();
    t_miss();
    t_timeout();
    t_late_hit();
    step(2);
    t_held();
    buttons = 3'd1; step(4); release_btn();
    check("R5 idle after miss", enable, 0);
    openRound();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule